// File: doc/BRIEF.md
# Immediate Branch and State-Exchange Unit

This block resolves the 32-bit immediate branch family of the processor's execute stage. Each cycle it may take one instruction word together with the program-counter value that the pipeline presents for it (a value that already runs ahead of the instruction), a valid strobe and the result of the condition check made elsewhere. One cycle later it reports whether the pipeline must be flushed and refilled, the new fetch address, whether the link register is to be written and with what, and whether the core must switch to the compressed 16-bit instruction state.

Three forms are handled. The first is a plain relative branch. The second is a branch that also saves a return address. The third is an unconditional relative branch that always saves a return address and switches to the 16-bit state. This third form is encoded by the otherwise unused condition value 4'b1111. It borrows the link bit as bit 1 of the byte offset, so its targets are halfword aligned. A parameter selects whether the core generation supports that third form. Without it, the 4'b1111 encoding is reported as an undefined instruction. Condition evaluation, the register file and fetch are outside the block. The caller presents only words whose bits 27:25 are 3'b101.

Top module: `branch_xfer_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are cleared to zero on that edge.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. All other outputs are zero whenever `out_valid` is low.
- R3: For a word whose condition field (bits 31:28) is not 4'b1111, with `cond_ok` high, the unit raises `flush_req` and drives `next_pc` = `pc_ahead` + (sign-extended bits 23:0 shifted left by 2).
- R4: For such an executed ordinary branch, `link_we` is high only when bit 24 is 1, and then `link_value` = `pc_ahead` − 4. When `link_we` is low, `link_value` is zero.
- R5: For a word that is not 4'b1111 and has `cond_ok` low, `out_valid` is high but `flush_req`, `link_we`, `thumb_set` and `undef_strobe` stay low, and `next_pc` is zero.
- R6: With `EXCH_EN` = 1, a word with condition 4'b1111 executes whatever the level of `cond_ok`. It drives `next_pc` = `pc_ahead` + ((sign-extended bits 23:0 shifted left by 2) OR (bit 24 at bit position 1)), raises `thumb_set`, `flush_req` and `link_we`, and sets `link_value` = `pc_ahead` − 4.
- R7: With `EXCH_EN` = 0, a word with condition 4'b1111 raises only `undef_strobe`. `flush_req`, `link_we` and `thumb_set` stay low and `next_pc` is zero. Any other condition value never raises `undef_strobe`.
- R8: All target and link arithmetic wraps modulo 2^32 in both directions.
- R9: An executed ordinary branch keeps the low two bits of `pc_ahead` in `next_pc`, and `thumb_set` is never high without `flush_req` and `link_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word and PC are presented this cycle |
| cond_ok | input | 1 | External condition check passed |
| instr_word | input | 32 | Branch-family instruction word |
| pc_ahead | input | 32 | Program-counter value as read by the instruction |
| out_valid | output | 1 | Result registers hold the outcome of the previous input |
| flush_req | output | 1 | Pipeline flush and refill from `next_pc` |
| next_pc | output | 32 | New fetch address, zero when no flush |
| link_we | output | 1 | Write the link register |
| link_value | output | 32 | Return address to write, zero when not writing |
| thumb_set | output | 1 | Enter the 16-bit instruction state |
| undef_strobe | output | 1 | Undefined-instruction trap request |

## Verification
The hardest case to reach is the 4'b1111 encoding with `cond_ok` low. A correct unit must ignore the external condition there, while the same low `cond_ok` must suppress every other word. The stimulus therefore drives the exchange words with `cond_ok` deliberately held low. It also sends the same words to a second instance built without the exchange form, so that the executed path and the undefined path are seen for identical inputs. Address wrap is reached by placing `pc_ahead` within a few bytes of either end of the address space.

// File: rtl/bx_pkg.sv
// Package: shared encodings for the immediate branch unit.
// Assumes a 4-bit condition field at the top of the instruction word.
package bx_pkg;

    // Resolved action for one presented instruction
    typedef enum logic [1:0] {
        BX_IDLE   = 2'd0,
        BX_BRANCH = 2'd1,
        BX_EXCH   = 2'd2,
        BX_UNDEF  = 2'd3
    } bx_form_e;

    localparam logic [3:0] COND_SPECIAL = 4'b1111;

endpackage

// File: rtl/bx_classify.sv
// Module: bx_classify
// Decides what a presented branch word does: nothing, ordinary branch,
// exchange branch or undefined trap. Assumes the word is from the
// immediate branch family. EXCH_EN selects how condition 1111 is treated.
module bx_classify
    import bx_pkg::*;
#(
    parameter bit EXCH_EN = 1'b1
) (
    input  logic       valid_i,
    input  logic       cond_ok_i,
    input  logic [3:0] cond_i,
    output bx_form_e   form_o
);

    bx_form_e special_form;

    // Pick the meaning of the special condition for this core generation
    generate
        if (EXCH_EN) begin : g_exch
            assign special_form = BX_EXCH;
        end else begin : g_noexch
            assign special_form = BX_UNDEF;
        end
    endgenerate

    // Combine strobe, condition field and external condition result
    always_comb begin
        form_o = BX_IDLE;
        if (valid_i) begin
            if (cond_i == COND_SPECIAL) begin
                form_o = special_form;
            end else if (cond_ok_i) begin
                form_o = BX_BRANCH;
            end
        end
    end

endmodule

// File: rtl/bx_target.sv
// Module: bx_target
// Computes the branch target and return address. Assumes the immediate
// is a byte offset divided by four. Sums wrap at XLEN bits.
module bx_target #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 24
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             half_i,
    input  logic             exch_i,
    output logic [XLEN-1:0]  target_o,
    output logic [XLEN-1:0]  link_o
);

    localparam int EXT_W = XLEN - IMM_W - 2;
    localparam logic [XLEN-1:0] LINK_BACK = XLEN'(4);

    logic [XLEN-1:0] offset_w;
    logic [XLEN-1:0] half_w;

    // Sign-extend the word offset to a byte offset
    assign offset_w = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};

    // Exchange form injects the link bit at byte-offset bit 1
    assign half_w = {{(XLEN-2){1'b0}}, (exch_i & half_i), 1'b0};

    // Wrapping sums for target and return address
    assign target_o = pc_i + (offset_w | half_w);
    assign link_o   = pc_i - LINK_BACK;

endmodule

// File: rtl/branch_xfer_unit.sv
// Module: branch_xfer_unit
// Execute-stage resolver for immediate branches, with optional
// state-exchange form. All outputs are registered and appear one cycle
// after the input strobe. Assumes bits 27:25 of the word are 101.
module branch_xfer_unit
    import bx_pkg::*;
#(
    parameter bit EXCH_EN = 1'b1,
    parameter int XLEN    = 32,
    parameter int IMM_W   = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            cond_ok,
    input  logic [XLEN-1:0] instr_word,
    input  logic [XLEN-1:0] pc_ahead,
    output logic            out_valid,
    output logic            flush_req,
    output logic [XLEN-1:0] next_pc,
    output logic            link_we,
    output logic [XLEN-1:0] link_value,
    output logic            thumb_set,
    output logic            undef_strobe
);

    localparam int LBIT = IMM_W;

    bx_form_e        form;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] link_addr;
    logic            take;
    logic            link_d;

    bx_classify #(.EXCH_EN(EXCH_EN)) u_classify (
        .valid_i   (in_valid),
        .cond_ok_i (cond_ok),
        .cond_i    (instr_word[XLEN-1 -: 4]),
        .form_o    (form)
    );

    bx_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_target (
        .pc_i     (pc_ahead),
        .imm_i    (instr_word[IMM_W-1:0]),
        .half_i   (instr_word[LBIT]),
        .exch_i   (form == BX_EXCH),
        .target_o (target),
        .link_o   (link_addr)
    );

    // Derive the flush and link decisions from the resolved form
    always_comb begin
        take   = (form == BX_BRANCH) || (form == BX_EXCH);
        link_d = (form == BX_EXCH) || ((form == BX_BRANCH) && instr_word[LBIT]);
    end

    // Register every result so it is valid one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            flush_req    <= 1'b0;
            next_pc      <= '0;
            link_we      <= 1'b0;
            link_value   <= '0;
            thumb_set    <= 1'b0;
            undef_strobe <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            flush_req    <= take;
            next_pc      <= take ? target : '0;
            link_we      <= link_d;
            link_value   <= link_d ? link_addr : '0;
            thumb_set    <= (form == BX_EXCH);
            undef_strobe <= (form == BX_UNDEF);
        end
    end

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !flush_req && !link_we && !undef_strobe); // R2
    AST_LINK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid ##1 link_we |-> link_value == $past(pc_ahead) - 32'd4); // R4
    AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        undef_strobe |-> !flush_req && !link_we && !thumb_set); // R7
    AST_WORD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid ##1 (flush_req && !thumb_set) |-> next_pc[1:0] == $past(pc_ahead[1:0])); // R9
    AST_EXCH_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
        thumb_set |-> flush_req && link_we); // R9

endmodule

// File: tb/branch_xfer_unit_bench.sv
module branch_xfer_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        cond_ok = 1'b0;
    logic [31:0] instr_word = '0;
    logic [31:0] pc_ahead = '0;

    logic        ov_a, fl_a, lw_a, th_a, ud_a;
    logic [31:0] np_a, lv_a;
    logic        ov_b, fl_b, lw_b, th_b, ud_b;
    logic [31:0] np_b, lv_b;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_xfer_unit #(.EXCH_EN(1'b1)) u_branch_xfer_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_ok(cond_ok),
        .instr_word(instr_word), .pc_ahead(pc_ahead),
        .out_valid(ov_a), .flush_req(fl_a), .next_pc(np_a), .link_we(lw_a),
        .link_value(lv_a), .thumb_set(th_a), .undef_strobe(ud_a)
    );

    branch_xfer_unit #(.EXCH_EN(1'b0)) u_branch_xfer_unit_v4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_ok(cond_ok),
        .instr_word(instr_word), .pc_ahead(pc_ahead),
        .out_valid(ov_b), .flush_req(fl_b), .next_pc(np_b), .link_we(lw_b),
        .link_value(lv_b), .thumb_set(th_b), .undef_strobe(ud_b)
    );

    // Compare one value and report a mismatch
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] woff(input logic [31:0] w);
        return {{6{w[23]}}, w[23:0], 2'b00};
    endfunction

    // Present one word for a single cycle and wait until results are visible
    task automatic issue(input logic [31:0] w, input logic [31:0] pc, input logic c);
        @(negedge clk);
        instr_word = w; pc_ahead = pc; cond_ok = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; cond_ok = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", {31'b0, ov_a}, 32'd0);
        chk("R1 flush", {31'b0, fl_a}, 32'd0);
        chk("R1 next_pc", np_a, 32'd0);
        chk("R1 link_value", lv_a, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_plain_forward();
        issue(32'hEA000010, 32'h0000_1000, 1'b1);
        chk("R2 valid", {31'b0, ov_a}, 32'd1);
        chk("R3 flush", {31'b0, fl_a}, 32'd1);
        chk("R3 target", np_a, 32'h1000 + woff(32'hEA000010));
        chk("R4 no link", {31'b0, lw_a}, 32'd0);
        chk("R4 link_value zero", lv_a, 32'd0);
        chk("R9 no thumb", {31'b0, th_a}, 32'd0);
    endtask

    task automatic t_link_backward();
        issue(32'hEBFFFFFE, 32'h0000_4000, 1'b1);
        chk("R3 back target", np_a, 32'h0000_3FF8);
        chk("R4 link we", {31'b0, lw_a}, 32'd1);
        chk("R4 link addr", lv_a, 32'h0000_3FFC);
    endtask

    task automatic t_cond_fail();
        issue(32'h0B000005, 32'h0000_2000, 1'b0);
        chk("R5 valid", {31'b0, ov_a}, 32'd1);
        chk("R5 flush", {31'b0, fl_a}, 32'd0);
        chk("R5 link", {31'b0, lw_a}, 32'd0);
        chk("R5 next_pc", np_a, 32'd0);
        chk("R5 undef", {31'b0, ud_a}, 32'd0);
    endtask

    task automatic t_exchange_even();
        issue(32'hFA000004, 32'h0000_2000, 1'b0);
        chk("R6 flush", {31'b0, fl_a}, 32'd1);
        chk("R6 target", np_a, 32'h0000_2010);
        chk("R6 thumb", {31'b0, th_a}, 32'd1);
        chk("R6 link", lv_a, 32'h0000_1FFC);
        chk("R6 link we", {31'b0, lw_a}, 32'd1);
        chk("R7 v4 undef", {31'b0, ud_b}, 32'd1);
        chk("R7 v4 flush", {31'b0, fl_b}, 32'd0);
        chk("R7 v4 link", {31'b0, lw_b}, 32'd0);
        chk("R7 v4 thumb", {31'b0, th_b}, 32'd0);
        chk("R7 v4 next_pc", np_b, 32'd0);
    endtask

    task automatic t_exchange_half();
        issue(32'hFB000004, 32'h0000_2000, 1'b1);
        chk("R6 half target", np_a, 32'h0000_2012);
        issue(32'hFBFFFFFF, 32'h0000_0100, 1'b1);
        chk("R6 half back", np_a, 32'h0000_00FE);
    endtask

    task automatic t_v4_plain();
        issue(32'hEB000001, 32'h0000_0800, 1'b1);
        chk("R7 v4 no undef", {31'b0, ud_b}, 32'd0);
        chk("R7 v4 branch", np_b, 32'h0000_0804);
        chk("R7 v4 links", {31'b0, lw_b}, 32'd1);
    endtask

    task automatic t_wrap();
        issue(32'hEA000004, 32'hFFFF_FFF8, 1'b1);
        chk("R8 wrap up", np_a, 32'h0000_0008);
        issue(32'hEBFFFFFF, 32'h0000_0000, 1'b1);
        chk("R8 wrap down", np_a, 32'hFFFF_FFFC);
        chk("R8 link wrap", lv_a, 32'hFFFF_FFFC);
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R2 idle valid", {31'b0, ov_a}, 32'd0);
        chk("R2 idle flush", {31'b0, fl_a}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_plain_forward();
        t_link_backward();
        t_cond_fail();
        t_exchange_even();
        t_exchange_half();
        t_v4_plain();
        t_wrap();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule